// File: doc/BRIEF.md
# Memory contention waiting-cycle tracker

This block sits next to a shared memory controller and the miss-status holding registers of one core. It measures the extra delay that the core's outstanding memory reads suffer because other cores use the same memory resources. It keeps that delay in a saturating waiting-cycle counter attached to each miss entry. Each cycle the controller presents one tracked request: the entry it belongs to, its core, bank and row. It also presents the state of the shared bus and of the target bank, and whether the request is being serviced, with a row-buffer miss flag. From this the block decides whether the request is being held up by a different core and charges the entry.

Three kinds of delay are charged. The first is a cycle spent waiting for a bus owned by another core. The second is a cycle spent waiting for a bank serving another core. The third is a row-buffer miss that would have been a row hit if the core ran alone. The block detects that case from a table of the last row each core opened in each bank, and it charges a fixed closed-versus-open penalty for it. Under a closed-page policy the row table is left out and no row charge is ever made. Software or the accounting logic reads any entry's count through a combinational read port, normally when the miss retires.

Top module: `contend_wait_tracker`

## Requirements
- R1: After reset every entry reads 0 on `rdCount`, and no core/bank slot of the row table holds a recorded row.
- R2: `allocValid` clears entry `allocIdx` to 0 and marks it live in the next cycle. It takes priority over a charge or a `freeValid` to the same entry in the same cycle.
- R3: In a cycle with `reqValid`, `busWant` and `busBusy` high and `busOwner` different from `reqCore`, live entry `reqIdx` gains 1.
- R4: When the busy bus or the busy bank is owned by `reqCore` itself, that resource adds nothing.
- R5: In a cycle with `reqValid` and `bankBusy` high and `bankOwner` different from `reqCore`, live entry `reqIdx` gains 1. This adds to any bus charge in the same cycle, so one cycle can add 2.
- R6: A cycle with `reqValid` and `svcValid` records `reqRow` as the last row of slot (`reqCore`, `reqBank`). The slot is kept separately per core and per bank, and the charge test in the same cycle uses the value recorded before.
- R7: With the open-page policy, a serviced request with `svcRowMiss` high adds `ROW_PENALTY` when its own slot holds a recorded row equal to `reqRow`.
- R8: A serviced row miss adds no penalty when its slot holds no row yet or holds a different row.
- R9: With the closed-page policy (`OPEN_PAGE` = 0), no row penalty is ever added.
- R10: A counter saturates at 2^`CNT_W`-1 (1023 by default) instead of wrapping.
- R11: Charges addressed to an entry that has not been allocated, or that has been freed by `freeValid`, are ignored. A freed entry keeps its value for reading.
- R12: `rdCount` shows entry `rdIdx` combinationally. A charge made at a clock edge is visible from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Allocate a miss entry |
| allocIdx | input | IDX_W (5) | Entry to allocate |
| freeValid | input | 1 | Retire a miss entry |
| freeIdx | input | IDX_W (5) | Entry to retire |
| reqValid | input | 1 | A tracked request is presented this cycle |
| reqIdx | input | IDX_W (5) | Miss entry of the request |
| reqCore | input | CORE_W (2) | Core that issued the request |
| reqBank | input | BANK_W (3) | Target bank |
| reqRow | input | ROW_W (20) | Target row |
| busWant | input | 1 | The request is ready for the bus |
| busBusy | input | 1 | The bus is occupied |
| busOwner | input | CORE_W (2) | Core holding the bus |
| bankBusy | input | 1 | The target bank is occupied |
| bankOwner | input | CORE_W (2) | Core the bank is serving |
| svcValid | input | 1 | The request is serviced by its bank this cycle |
| svcRowMiss | input | 1 | That service is a row-buffer miss |
| rdIdx | input | IDX_W (5) | Entry to read |
| rdCount | output | CNT_W (10) | Waiting cycles of entry `rdIdx` |

## Verification
On every cycle the assertions check four things about the read entry. An allocation reads back as zero. A count never goes down unless the entry is allocated again. A cycle in which every busy resource belongs to the requesting core charges nothing. The per-cycle step never exceeds the largest legal charge, which is 2 under a closed-page policy. Which core's open-row record matches and which exact amount is added depend on history across many cycles. Only the bench's scenarios show these: the per-core, per-bank row record, the penalty on a matching miss, its absence on a mismatch, saturation, and the freezing of freed entries. The bench compares both policy variants against its model under directed and random traffic.

// File: rtl/wait_track_pkg.sv
package wait_track_pkg;
  // Strobes from the classifier to the counter datapath
  typedef struct packed {
    logic busHit;    // request waits on a bus held by another core
    logic bankHit;   // request waits on a bank serving another core
    logic rowHit;    // serviced row miss caused by interference
    logic clearEn;   // allocate an entry
    logic retireEn;  // retire an entry
  } wait_strobe_t;
endpackage

// File: rtl/open_row_table.sv
module open_row_table #(
  parameter int CORE_W = 2,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CORE_W-1:0] wrCore,
  input  logic [BANK_W-1:0] wrBank,
  input  logic [ROW_W-1:0]  wrRow,
  input  logic [CORE_W-1:0] lkCore,
  input  logic [BANK_W-1:0] lkBank,
  output logic              lkValid,
  output logic [ROW_W-1:0]  lkRow
);
  localparam int SLOT_W = CORE_W + BANK_W;
  localparam int SLOTS  = 1 << SLOT_W;

  logic [ROW_W-1:0] rowQ [SLOTS];
  logic [SLOTS-1:0] seenQ;
  logic [SLOT_W-1:0] wrSlot, lkSlot;

  assign wrSlot  = {wrCore, wrBank};
  assign lkSlot  = {lkCore, lkBank};
  assign lkValid = seenQ[lkSlot];
  assign lkRow   = rowQ[lkSlot];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenQ <= '0;
      for (int s = 0; s < SLOTS; s++) rowQ[s] <= '0;
    end else if (wrEn) begin
      seenQ[wrSlot] <= 1'b1;
      rowQ[wrSlot]  <= wrRow;
    end
  end
endmodule

// File: rtl/wait_ctrl.sv
module wait_ctrl
  import wait_track_pkg::*;
#(
  parameter int CORE_W = 2,
  parameter int ROW_W  = 20
) (
  input  logic              reqValid,
  input  logic [CORE_W-1:0] reqCore,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic              busWant,
  input  logic              busBusy,
  input  logic [CORE_W-1:0] busOwner,
  input  logic              bankBusy,
  input  logic [CORE_W-1:0] bankOwner,
  input  logic              svcValid,
  input  logic              svcRowMiss,
  input  logic              oraValid,
  input  logic [ROW_W-1:0]  oraRow,
  input  logic              allocValid,
  input  logic              freeValid,
  output wait_strobe_t      strobe,
  output logic              oraWr
);
  logic foreignBus, foreignBank, ownRowLost;

  always_comb begin
    foreignBus  = busWant && busBusy && (busOwner != reqCore);
    foreignBank = bankBusy && (bankOwner != reqCore);
    // Own last row in the bank equals the request, yet the row was closed
    ownRowLost  = svcValid && svcRowMiss && oraValid && (oraRow == reqRow);

    strobe.busHit   = reqValid && foreignBus;
    strobe.bankHit  = reqValid && foreignBank;
    strobe.rowHit   = reqValid && ownRowLost;
    strobe.clearEn  = allocValid;
    strobe.retireEn = freeValid;
    oraWr           = reqValid && svcValid;
  end
endmodule

// File: rtl/wait_datapath.sv
module wait_datapath
  import wait_track_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int IDX_W       = 5,
  parameter int CNT_W       = 10,
  parameter int ROW_PENALTY = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  wait_strobe_t     strobe,
  input  logic [IDX_W-1:0] reqIdx,
  input  logic [IDX_W-1:0] allocIdx,
  input  logic [IDX_W-1:0] freeIdx,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [CNT_W-1:0] rdCount
);
  localparam int SUM_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [SUM_W-1:0] addAmt;
  logic [CNT_W-1:0] cntArr [NUM_ENTRIES];

  always_comb begin
    addAmt = SUM_W'(strobe.busHit) + SUM_W'(strobe.bankHit)
           + (strobe.rowHit ? SUM_W'(ROW_PENALTY) : '0);
  end

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
    logic             liveQ;
    logic [CNT_W-1:0] cntQ;
    logic [SUM_W-1:0] sum;
    logic             allocHere, freeHere, chargeHere;

    always_comb begin
      allocHere  = strobe.clearEn  && (allocIdx == IDX_W'(e));
      freeHere   = strobe.retireEn && (freeIdx  == IDX_W'(e));
      chargeHere = liveQ && (reqIdx == IDX_W'(e));
      sum        = {1'b0, cntQ} + addAmt;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ  <= '0;
        liveQ <= 1'b0;
      end else begin
        if (allocHere)       cntQ <= '0;
        else if (chargeHere) cntQ <= sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
        if (allocHere)       liveQ <= 1'b1;
        else if (freeHere)   liveQ <= 1'b0;
      end
    end

    assign cntArr[e] = cntQ;
  end

  assign rdCount = cntArr[rdIdx];
endmodule

// File: rtl/contend_wait_tracker.sv
module contend_wait_tracker
  import wait_track_pkg::*;
#(
  parameter int NUM_CORES   = 4,
  parameter int NUM_BANKS   = 8,
  parameter int ROW_W       = 20,
  parameter int NUM_ENTRIES = 32,
  parameter int CNT_W       = 10,
  parameter int ROW_PENALTY = 12,
  parameter bit OPEN_PAGE   = 1'b1,
  localparam int CORE_W = $clog2(NUM_CORES),
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int IDX_W  = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  input  logic [IDX_W-1:0]  allocIdx,
  input  logic              freeValid,
  input  logic [IDX_W-1:0]  freeIdx,
  input  logic              reqValid,
  input  logic [IDX_W-1:0]  reqIdx,
  input  logic [CORE_W-1:0] reqCore,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic              busWant,
  input  logic              busBusy,
  input  logic [CORE_W-1:0] busOwner,
  input  logic              bankBusy,
  input  logic [CORE_W-1:0] bankOwner,
  input  logic              svcValid,
  input  logic              svcRowMiss,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [CNT_W-1:0]  rdCount
);
  wait_strobe_t     strobe;
  logic             oraWr, oraValid;
  logic [ROW_W-1:0] oraRow;

  if (OPEN_PAGE) begin : g_open
    open_row_table #(.CORE_W(CORE_W), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_ora (
      .clk(clk), .rstN(rstN),
      .wrEn(oraWr), .wrCore(reqCore), .wrBank(reqBank), .wrRow(reqRow),
      .lkCore(reqCore), .lkBank(reqBank),
      .lkValid(oraValid), .lkRow(oraRow)
    );
  end else begin : g_closed
    // No row history under a closed-page policy
    assign oraValid = 1'b0;
    assign oraRow   = '0;
  end

  wait_ctrl #(.CORE_W(CORE_W), .ROW_W(ROW_W)) u_ctrl (
    .reqValid(reqValid), .reqCore(reqCore), .reqRow(reqRow),
    .busWant(busWant), .busBusy(busBusy), .busOwner(busOwner),
    .bankBusy(bankBusy), .bankOwner(bankOwner),
    .svcValid(svcValid), .svcRowMiss(svcRowMiss),
    .oraValid(oraValid), .oraRow(oraRow),
    .allocValid(allocValid), .freeValid(freeValid),
    .strobe(strobe), .oraWr(oraWr)
  );

  wait_datapath #(
    .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W),
    .CNT_W(CNT_W), .ROW_PENALTY(ROW_PENALTY)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqIdx(reqIdx), .allocIdx(allocIdx), .freeIdx(freeIdx),
    .rdIdx(rdIdx), .rdCount(rdCount)
  );
endmodule

// File: rtl/wait_track_checker.sv
module wait_track_checker #(
  parameter int CORE_W      = 2,
  parameter int IDX_W       = 5,
  parameter int CNT_W       = 10,
  parameter int ROW_PENALTY = 12,
  parameter bit OPEN_PAGE   = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              allocValid,
  input logic [IDX_W-1:0]  allocIdx,
  input logic              reqValid,
  input logic [IDX_W-1:0]  reqIdx,
  input logic [CORE_W-1:0] reqCore,
  input logic              busWant,
  input logic              busBusy,
  input logic [CORE_W-1:0] busOwner,
  input logic              bankBusy,
  input logic [CORE_W-1:0] bankOwner,
  input logic              svcValid,
  input logic [IDX_W-1:0]  rdIdx,
  input logic [CNT_W-1:0]  rdCount
);
  // R2: an allocated entry reads zero in the following cycle
  assert_alloc_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (allocValid && allocIdx == rdIdx) |=> (!$stable(rdIdx) || rdCount == '0));

  // R10: a watched count never drops unless it is allocated again
  assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(rdIdx) && !$past(allocValid)) |-> (rdCount >= $past(rdCount)));

  // R4: resources held by the requester itself charge nothing
  assert_own_owner_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqIdx == rdIdx && !svcValid && !allocValid &&
     (!busWant || !busBusy || busOwner == reqCore) &&
     (!bankBusy || bankOwner == reqCore))
    |=> (!$stable(rdIdx) || rdCount == $past(rdCount)));

  // R3, R5, R7: one cycle adds at most bus + bank + row penalty
  assert_step_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    $stable(rdIdx) |-> (int'(rdCount) <= int'($past(rdCount)) + 2 + ROW_PENALTY));

  if (!OPEN_PAGE) begin : g_closed_chk
    // R9: without row history a cycle adds at most the two contention cycles
    assert_closed_step_R9: assert property (@(posedge clk) disable iff (!rstN)
      $stable(rdIdx) |-> (int'(rdCount) <= int'($past(rdCount)) + 2));
  end
endmodule

bind contend_wait_tracker wait_track_checker #(
  .CORE_W(CORE_W), .IDX_W(IDX_W), .CNT_W(CNT_W),
  .ROW_PENALTY(ROW_PENALTY), .OPEN_PAGE(OPEN_PAGE)
) u_chk (.*);

// File: tb/contend_wait_tracker_tb.sv
`timescale 1ns/1ps
module contend_wait_tracker_tb;
  localparam int NC = 4, NB = 8, RW = 20, NE = 32, CW = 10, PEN = 12;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic allocValid, freeValid, reqValid, busWant, busBusy, bankBusy, svcValid, svcRowMiss;
  logic [4:0] allocIdx, freeIdx, reqIdx, rdIdx;
  logic [1:0] reqCore, busOwner, bankOwner;
  logic [2:0] reqBank;
  logic [RW-1:0] reqRow;
  logic [CW-1:0] rdCount, rdCountCp;

  int total = 0, fails = 0;
  bit done = 0;

  int cntO [NE];
  int cntC [NE];
  bit live [NE];
  int oraRow [NC][NB];
  bit oraSeen [NC][NB];

  always #4 clk = ~clk;

  contend_wait_tracker u_dut (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocIdx(allocIdx),
    .freeValid(freeValid), .freeIdx(freeIdx), .reqValid(reqValid), .reqIdx(reqIdx),
    .reqCore(reqCore), .reqBank(reqBank), .reqRow(reqRow), .busWant(busWant),
    .busBusy(busBusy), .busOwner(busOwner), .bankBusy(bankBusy), .bankOwner(bankOwner),
    .svcValid(svcValid), .svcRowMiss(svcRowMiss), .rdIdx(rdIdx), .rdCount(rdCount));

  contend_wait_tracker #(.OPEN_PAGE(1'b0)) u_dutCp (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocIdx(allocIdx),
    .freeValid(freeValid), .freeIdx(freeIdx), .reqValid(reqValid), .reqIdx(reqIdx),
    .reqCore(reqCore), .reqBank(reqBank), .reqRow(reqRow), .busWant(busWant),
    .busBusy(busBusy), .busOwner(busOwner), .bankBusy(bankBusy), .bankOwner(bankOwner),
    .svcValid(svcValid), .svcRowMiss(svcRowMiss), .rdIdx(rdIdx), .rdCount(rdCountCp));

  function automatic int satAdd(int a, int b);
    return (a + b > CMAX) ? CMAX : a + b;
  endfunction

  task automatic idle();
    allocValid = 0; freeValid = 0; reqValid = 0; busWant = 0; busBusy = 0;
    bankBusy = 0; svcValid = 0; svcRowMiss = 0; allocIdx = 0; freeIdx = 0;
    reqIdx = 0; reqCore = 0; reqBank = 0; reqRow = 0; busOwner = 0; bankOwner = 0;
  endtask

  task automatic modelStep();
    bit rowLost;
    int base;
    rowLost = reqValid && svcValid && svcRowMiss && oraSeen[reqCore][reqBank]
              && (oraRow[reqCore][reqBank] == int'(reqRow));
    base = int'(reqValid && busWant && busBusy && busOwner != reqCore)
         + int'(reqValid && bankBusy && bankOwner != reqCore);
    if (reqValid && live[reqIdx]) begin
      cntO[reqIdx] = satAdd(cntO[reqIdx], base + (rowLost ? PEN : 0));
      cntC[reqIdx] = satAdd(cntC[reqIdx], base);
    end
    if (reqValid && svcValid) begin
      oraSeen[reqCore][reqBank] = 1;
      oraRow[reqCore][reqBank]  = int'(reqRow);
    end
    if (freeValid) live[freeIdx] = 0;
    if (allocValid) begin
      live[allocIdx] = 1; cntO[allocIdx] = 0; cntC[allocIdx] = 0;
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    modelStep();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int idx);
    rdIdx = 5'(idx);
    #1;
    total++;
    if (rdCount !== CW'(cntO[idx])) begin
      fails++;
      $display("FAIL %s open-page entry %0d: got %0d expected %0d", tag, idx, rdCount, cntO[idx]);
    end
    total++;
    if (rdCountCp !== CW'(cntC[idx])) begin
      fails++;
      $display("FAIL %s closed-page entry %0d: got %0d expected %0d", tag, idx, rdCountCp, cntC[idx]);
    end
  endtask

  task automatic setReq(input int idx, input int core, input int bank, input int row);
    reqValid = 1; reqIdx = 5'(idx); reqCore = 2'(core); reqBank = 3'(bank); reqRow = RW'(row);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    idle();
    rdIdx = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1: reset state
    for (int i = 0; i < NE; i++) chk("R1", i);

    // R2: allocate entry 3
    allocValid = 1; allocIdx = 3; cycle(); idle();
    chk("R2", 3);

    // R3: bus held by another core, 5 cycles
    setReq(3, 1, 2, 0); busWant = 1; busBusy = 1; busOwner = 2;
    repeat (5) cycle();
    chk("R3", 3);

    // R4: bus and bank held by the same core
    busOwner = 1; bankBusy = 1; bankOwner = 1;
    repeat (4) cycle();
    chk("R4", 3);

    // R5: bank held by another core, bus free
    busBusy = 0; bankOwner = 3;
    repeat (3) cycle();
    chk("R5", 3);
    busBusy = 1; busOwner = 0; cycle();
    chk("R5 both", 3);
    idle();

    // R8: row miss with no recorded row; R6 records it
    setReq(3, 1, 2, 'h12345); svcValid = 1; svcRowMiss = 1; cycle();
    chk("R8 empty", 3);
    // R7/R9: same row again, own record matches
    cycle();
    chk("R7 R9 R6", 3);
    // R8: different row, no penalty
    setReq(3, 1, 2, 'h54321); svcValid = 1; svcRowMiss = 1; cycle();
    chk("R8 mismatch", 3);
    // R6: another core's slot in the same bank is separate
    setReq(3, 2, 2, 'h54321); svcValid = 1; svcRowMiss = 1; cycle();
    chk("R6 per core", 3);
    // R6: another bank of the same core is separate
    setReq(3, 1, 5, 'h54321); svcValid = 1; svcRowMiss = 1; cycle();
    chk("R6 per bank", 3);
    idle();

    // R11: freed entry ignores charges
    freeValid = 1; freeIdx = 3; cycle(); idle();
    setReq(3, 1, 0, 0); busWant = 1; busBusy = 1; busOwner = 3; bankBusy = 1; bankOwner = 2;
    repeat (4) cycle();
    chk("R11 freed", 3);
    // R11: never-allocated entry ignores charges
    reqIdx = 9; repeat (3) cycle();
    chk("R11 unallocated", 9);
    idle();

    // R10: saturation
    allocValid = 1; allocIdx = 5; cycle(); idle();
    setReq(5, 1, 2, 'h54321); busWant = 1; busBusy = 1; busOwner = 0;
    bankBusy = 1; bankOwner = 3; svcValid = 1; svcRowMiss = 1;
    repeat (80) cycle();
    chk("R10", 5);
    // R12: read port selects per entry
    chk("R12", 3);
    chk("R12", 7);

    // R2: allocation wins over charge and free in the same cycle
    allocValid = 1; allocIdx = 5; freeValid = 1; freeIdx = 5; cycle(); idle();
    chk("R2 priority", 5);

    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      allocValid = ($urandom_range(0, 7) == 0); allocIdx = 5'($urandom_range(0, NE - 1));
      freeValid  = ($urandom_range(0, 7) == 0); freeIdx  = 5'($urandom_range(0, NE - 1));
      reqValid   = ($urandom_range(0, 3) != 0); reqIdx   = 5'($urandom_range(0, NE - 1));
      reqCore    = 2'($urandom_range(0, NC - 1)); reqBank = 3'($urandom_range(0, NB - 1));
      reqRow     = RW'($urandom_range(0, 3));
      busWant    = $urandom_range(0, 1) == 1; busBusy = $urandom_range(0, 1) == 1;
      busOwner   = 2'($urandom_range(0, NC - 1));
      bankBusy   = $urandom_range(0, 1) == 1; bankOwner = 2'($urandom_range(0, NC - 1));
      svcValid   = ($urandom_range(0, 2) == 0); svcRowMiss = $urandom_range(0, 1) == 1;
      cycle();
      chk("R3 R5 R7 random", $urandom_range(0, NE - 1));
    end
    idle();
    cycle();
    for (int i = 0; i < NE; i++) chk("R10 R11 final", i);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule